// File: doc/BRIEF.md
# Pulse-Response Superposition Channel Emulator

This block stands in for a lossy serial link inside an all-digital simulation or emulation build. A transmit bit stream enters at one bit per data period. Each period is divided into a fixed number of sub-bit time steps, and at every step the block produces an 11-bit signed code for the voltage at the receiver input. It forms this code by superposing a stored single-bit pulse response. The current bit and the four bits before it each contribute the table sample at their own offset. A one adds the sample and a zero subtracts it.

The pulse-response table is written through a plain address/data/strobe port, normally while reset is held. The stored response begins at time zero, so the line's flight time has been removed from it. The block puts that flight time back by delaying the computed code through a circular buffer by a programmable number of sub-steps. A sign slicer turns the delayed code into a received bit. Both the slicer output and the code are marked valid once the delay buffer holds only values computed since reset.

Top module: `pulseChanEmu`

## Requirements
- R1: While reset is held, rxValid, rxBit and rxCode are 0. The bit history resets to all zeros, so the first valid outputs are the negated sums of the table entries.
- R2: For sub-step p and history position k (k=0 is the newest bit), the term is table entry k*STEPS+p, added when that bit is 1 and subtracted when it is 0. The output is the sum of the terms for k=0..TAPS-1.
- R3: A bit older than TAPS-1 periods has no effect on the output.
- R4: txBit is sampled on the clock edge at which the sub-step counter wraps from STEPS-1 to 0. After that edge it is history position 0, and the older bits move up by one position.
- R5: The sum is saturated to the signed 11-bit range [-1024, 1023].
- R6: rxCode after clock edge e equals the sum computed for the state after edge e-2-tofSteps, counting edges from reset release. tofSteps=0 therefore gives a two-cycle latency.
- R7: rxValid is 0 until edge tofSteps+2 after reset release, and from then on it stays 1.
- R8: rxBit is 1 exactly when rxValid is 1 and rxCode is non-negative (sign bit 0). Otherwise it is 0.
- R9: A write with tblWe high stores tblData at tblAddr, and later sums use the new value. Writes are accepted while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-step clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBit | input | 1 | Transmit bit, sampled at the counter wrap |
| tblWe | input | 1 | Table write strobe |
| tblAddr | input | ADDR_W | Table write address |
| tblData | input | CODE_W | Signed table sample |
| tofSteps | input | DLY_W | Flight-time delay in sub-steps, held static |
| rxCode | output | CODE_W | Signed receiver-input code |
| rxBit | output | 1 | Sliced received bit |
| rxValid | output | 1 | Output valid |

## Verification
The assertions check the cycle-level rules on every cycle: the counter wrap, the shifting and holding of the bit history, saturation of the wide sum, the zero-delay pass-through, the persistence of rxValid, and the slicer relation. Only the bench's scenarios can show that the full superposition arithmetic is correct. That includes the choice of table index and the sign for each history position, the exclusion of bits older than the window, the exact latency for non-zero flight times, and the effect of table writes made during reset. The bench checks all of these against an arithmetic model over whole runs at several delays.

// File: rtl/pulseChanPkg.sv
package pulseChanPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wrap;     // sub-step counter is at its last step this cycle
    logic advance;  // pipeline and delay buffer move this cycle
  } chanStrobe_t;
endpackage

// File: rtl/pulseChanCtrl.sv
module pulseChanCtrl
  import pulseChanPkg::*;
#(
  parameter int STEPS     = 200,
  parameter int TAPS      = 5,
  parameter int DLY_DEPTH = 1024,
  localparam int STEP_W   = $clog2(STEPS),
  localparam int DLY_W    = $clog2(DLY_DEPTH),
  localparam int CNT_W    = DLY_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBit,
  input  logic [DLY_W-1:0]  tofSteps,
  output logic [STEP_W-1:0] stepIdx,
  output logic [TAPS-1:0]   hist,
  output chanStrobe_t       strobe,
  output logic              outValid
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(DLY_DEPTH + 1);

  logic [CNT_W-1:0] fillCnt;
  logic             atLast;

  assign atLast         = (stepIdx == LAST_STEP);
  assign strobe.wrap    = atLast;
  assign strobe.advance = rstN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (atLast) begin
      stepIdx <= '0;
    end else begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  // bit history: position 0 is the newest bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '0;
    end else if (atLast) begin
      hist <= {hist[TAPS-2:0], txBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (fillCnt != CNT_MAX) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign outValid = (fillCnt >= (CNT_W'(tofSteps) + CNT_W'(2)));
endmodule

// File: rtl/pulseChanDatapath.sv
module pulseChanDatapath
  import pulseChanPkg::*;
#(
  parameter int STEPS     = 200,
  parameter int TAPS      = 5,
  parameter int CODE_W    = 11,
  parameter int DLY_DEPTH = 1024,
  localparam int TBL_N    = STEPS * TAPS,
  localparam int ADDR_W   = $clog2(TBL_N),
  localparam int STEP_W   = $clog2(STEPS),
  localparam int DLY_W    = $clog2(DLY_DEPTH),
  localparam int ACC_W    = CODE_W + $clog2(TAPS) + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chanStrobe_t              strobe,
  input  logic [STEP_W-1:0]        stepIdx,
  input  logic [TAPS-1:0]          hist,
  input  logic                     tblWe,
  input  logic [ADDR_W-1:0]        tblAddr,
  input  logic [CODE_W-1:0]        tblData,
  input  logic [DLY_W-1:0]         tofSteps,
  output logic signed [ACC_W-1:0]  sumWide,
  output logic [CODE_W-1:0]        sumQ,
  output logic [CODE_W-1:0]        codeOut
);
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-CODE_W+1){1'b1}}, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0]       respTbl [TBL_N];
  logic [CODE_W-1:0]       dlyBuf  [DLY_DEPTH];
  logic signed [ACC_W-1:0] term    [TAPS];
  logic [DLY_W-1:0]        wrPtr;
  logic [DLY_W-1:0]        rdPtr;
  logic [CODE_W-1:0]       satCode;

  // table write port, no reset on storage
  always_ff @(posedge clk) begin
    if (tblWe) begin
      respTbl[tblAddr] <= tblData;
    end
  end

  // one signed term per history position
  for (genvar k = 0; k < TAPS; k++) begin : gTap
    logic [ADDR_W-1:0]       rdIdx;
    logic [CODE_W-1:0]       entry;
    logic signed [ACC_W-1:0] entryExt;
    assign rdIdx    = ADDR_W'(k * STEPS) + ADDR_W'(stepIdx);
    assign entry    = respTbl[rdIdx];
    assign entryExt = {{(ACC_W-CODE_W){entry[CODE_W-1]}}, entry};
    assign term[k]  = hist[k] ? entryExt : -entryExt;
  end

  always_comb begin
    sumWide = '0;
    for (int k = 0; k < TAPS; k++) begin
      sumWide = sumWide + term[k];
    end
  end

  always_comb begin
    if (sumWide > SAT_HI) begin
      satCode = SAT_HI[CODE_W-1:0];
    end else if (sumWide < SAT_LO) begin
      satCode = SAT_LO[CODE_W-1:0];
    end else begin
      satCode = sumWide[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumQ <= '0;
    end else if (strobe.advance) begin
      sumQ <= satCode;
    end
  end

  // flight-time delay line
  assign rdPtr = wrPtr - tofSteps;

  always_ff @(posedge clk) begin
    if (strobe.advance) begin
      dlyBuf[wrPtr] <= sumQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      codeOut <= '0;
    end else if (strobe.advance) begin
      wrPtr   <= wrPtr + 1'b1;
      codeOut <= (tofSteps == '0) ? sumQ : dlyBuf[rdPtr];
    end
  end
endmodule

// File: rtl/pulseChanEmu.sv
module pulseChanEmu
  import pulseChanPkg::*;
#(
  parameter int STEPS     = 200,
  parameter int TAPS      = 5,
  parameter int CODE_W    = 11,
  parameter int DLY_DEPTH = 1024,
  localparam int TBL_N    = STEPS * TAPS,
  localparam int ADDR_W   = $clog2(TBL_N),
  localparam int STEP_W   = $clog2(STEPS),
  localparam int DLY_W    = $clog2(DLY_DEPTH),
  localparam int ACC_W    = CODE_W + $clog2(TAPS) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBit,
  input  logic              tblWe,
  input  logic [ADDR_W-1:0] tblAddr,
  input  logic [CODE_W-1:0] tblData,
  input  logic [DLY_W-1:0]  tofSteps,
  output logic [CODE_W-1:0] rxCode,
  output logic              rxBit,
  output logic              rxValid
);
  chanStrobe_t             strobe;
  logic [STEP_W-1:0]       stepIdx;
  logic [TAPS-1:0]         hist;
  logic signed [ACC_W-1:0] sumWide;
  logic [CODE_W-1:0]       sumQ;

  pulseChanCtrl #(
    .STEPS(STEPS), .TAPS(TAPS), .DLY_DEPTH(DLY_DEPTH)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .txBit(txBit), .tofSteps(tofSteps),
    .stepIdx(stepIdx), .hist(hist), .strobe(strobe), .outValid(rxValid)
  );

  pulseChanDatapath #(
    .STEPS(STEPS), .TAPS(TAPS), .CODE_W(CODE_W), .DLY_DEPTH(DLY_DEPTH)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .hist(hist), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .tofSteps(tofSteps), .sumWide(sumWide), .sumQ(sumQ), .codeOut(rxCode)
  );

  // sign slicer
  assign rxBit = rxValid & ~rxCode[CODE_W-1];
endmodule

// File: rtl/pulseChanChecker.sv
module pulseChanChecker #(
  parameter int STEPS  = 200,
  parameter int TAPS   = 5,
  parameter int CODE_W = 11,
  parameter int STEP_W = 8,
  parameter int DLY_W  = 10,
  parameter int ACC_W  = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [STEP_W-1:0]       stepIdx,
  input logic [TAPS-1:0]         hist,
  input logic signed [ACC_W-1:0] sumWide,
  input logic [CODE_W-1:0]       sumQ,
  input logic [CODE_W-1:0]       rxCode,
  input logic                    rxBit,
  input logic                    rxValid,
  input logic [DLY_W-1:0]        tofSteps
);
  localparam logic signed [ACC_W-1:0] HI_W =
    {{(ACC_W-CODE_W+1){1'b0}}, {(CODE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LO_W =
    {{(ACC_W-CODE_W+1){1'b1}}, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] HI_C = {1'b0, {(CODE_W-1){1'b1}}};
  localparam logic [CODE_W-1:0] LO_C = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == LAST) |=> (stepIdx == '0)); // R4
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == LAST) |=> (hist[TAPS-1:1] == $past(hist[TAPS-2:0]))); // R4
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx != LAST) |=> $stable(hist)); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sumWide > HI_W) |=> (sumQ == HI_C)); // R5
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sumWide < LO_W) |=> (sumQ == LO_C)); // R5
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && tofSteps == '0 && $past(tofSteps) == '0)
      |-> (rxCode == $past(sumQ))); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && $stable(tofSteps)) |=> rxValid); // R7
  AST_SLICE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxCode[CODE_W-1]) |-> rxBit); // R8
  AST_SLICE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!rxValid || rxCode[CODE_W-1]) |-> !rxBit); // R8
endmodule

bind pulseChanEmu pulseChanChecker #(
  .STEPS(STEPS), .TAPS(TAPS), .CODE_W(CODE_W),
  .STEP_W(STEP_W), .DLY_W(DLY_W), .ACC_W(ACC_W)
) uChk (
  .clk(clk), .rstN(rstN), .stepIdx(stepIdx), .hist(hist),
  .sumWide(sumWide), .sumQ(sumQ), .rxCode(rxCode), .rxBit(rxBit),
  .rxValid(rxValid), .tofSteps(tofSteps)
);

// File: tb/tb_pulseChanEmu.sv
module tb_pulseChanEmu;
  localparam int S     = 10;
  localparam int T     = 5;
  localparam int CW    = 11;
  localparam int DEPTH = 64;
  localparam int N     = S * T;
  localparam int AW    = $clog2(N);
  localparam int DW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txBit = 1'b0;
  logic          tblWe = 1'b0;
  logic [AW-1:0] tblAddr = '0;
  logic [CW-1:0] tblData = '0;
  logic [DW-1:0] tofSteps = '0;
  logic [CW-1:0] rxCode;
  logic          rxBit;
  logic          rxValid;

  int checks = 0;
  int fails  = 0;
  int tblM [N];
  int bits [256];

  always #2ns clk = ~clk;

  pulseChanEmu #(.STEPS(S), .TAPS(T), .CODE_W(CW), .DLY_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .txBit(txBit), .tblWe(tblWe), .tblAddr(tblAddr),
    .tblData(tblData), .tofSteps(tofSteps), .rxCode(rxCode), .rxBit(rxBit),
    .rxValid(rxValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model of the sum for the state after edge x
  function automatic int model(input int x);
    int step = x % S;
    int nb   = x / S;
    int acc  = 0;
    for (int k = 0; k < T; k++) begin
      int idx = nb - 1 - k;
      int b   = (idx >= 0) ? bits[idx] : 0;
      acc += (b != 0) ? tblM[k*S + step] : -tblM[k*S + step];
    end
    if (acc > 1023) acc = 1023;
    if (acc < -1024) acc = -1024;
    return acc;
  endfunction

  task automatic writeEntry(input int a, input int v);
    @(negedge clk);
    tblWe   = 1'b1;
    tblAddr = AW'(a);
    tblData = CW'(v);
    tblM[a] = v;
    @(negedge clk);
    tblWe   = 1'b0;
  endtask

  task automatic runCase(input int tof, input int cycles, input string req);
    @(negedge clk);
    rstN     = 1'b0;
    txBit    = 1'b0;
    tofSteps = DW'(tof);
    repeat (3) @(negedge clk);
    chk("R1 reset rxValid", int'(rxValid), 0);
    chk("R1 reset rxCode", int'(rxCode), 0);
    chk("R1 reset rxBit", int'(rxBit), 0);
    rstN = 1'b1;
    for (int e = 1; e <= cycles; e++) begin
      txBit = (e >= S && (e % S) == 0) ? bits[e/S - 1][0] : 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R7 valid timing", int'(rxValid), (e >= tof + 2) ? 1 : 0);
      if (e >= tof + 2) begin
        int ex = model(e - 2 - tof);
        int ac = int'($signed(rxCode));
        if (e - 2 - tof < S) chk("R1 zero-history output", ac, ex);
        else chk(req, ac, ex);
        chk("R8 slicer", int'(rxBit), (ex >= 0) ? 1 : 0);
      end else begin
        chk("R8 slicer idle", int'(rxBit), 0);
      end
    end
  endtask

  initial begin
    #(4ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // run A: mixed table, pseudo-random bits, zero delay
    for (int m = 0; m < 256; m++) bits[m] = ((m * 7 + 3) % 11) > 5 ? 1 : 0;
    rstN = 1'b0;
    for (int i = 0; i < N; i++) writeEntry(i, ((i * 37 + 11) % 201) - 100);
    runCase(0, 400, "R2 R3 R4 R6 superposition");

    // run B: rewrite the newest-bit segment during reset, delay 5
    rstN = 1'b0;
    for (int i = 0; i < S; i++) writeEntry(i, ((i * 13) % 300) - 150);
    for (int m = 0; m < 256; m++) bits[m] = ((m * 5 + 1) % 7) > 2 ? 1 : 0;
    runCase(5, 400, "R9 R2 R6 rewritten table");

    // run C: saturating table, runs of equal bits, long delay
    rstN = 1'b0;
    for (int i = 0; i < N; i++) writeEntry(i, 420 - (i % 3));
    for (int m = 0; m < 256; m++) bits[m] = (m / 6) % 2;
    runCase(37, 600, "R5 R3 R6 saturation");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule